// File: doc/BRIEF.md
# Operand Forwarding Unit

This block sits in front of the ALU in the execute stage of a five-stage pipeline. For each of the two source operands of the instruction now in execute, it compares the source register index with the destination index of the two older instructions still in flight. One older instruction has just left execute and sits in the execute/memory register. The other is about to write back and sits in the memory/writeback register. If a live producer targets that register, the unit routes the producer's value straight to the ALU input. The register file read is used only when no producer matches.

The unit is purely combinational. It produces a 2-bit source select per operand and contains the two 3-input operand multiplexers. It also builds the late-stage bypass value itself, from the load data or the ALU result held in the memory/writeback register. Stall generation for the load-use case is outside the block. When the instruction in execute needs a value that a load is still fetching from memory, no bypass can supply it, and the pipeline must hold the consumer back. The unit adds nothing for that case.

Top module: `opfwd_unit`

## Requirements
- R1: When `ex_rs1` equals `exm_rd`, `exm_wen` is 1 and `exm_rd` is not 0, `a_sel` is 2'b01 and `alu_a` equals `exm_alu_result`.
- R2: The same rule holds for `ex_rs2`: `b_sel` is 2'b01 and `alu_b` equals `exm_alu_result`.
- R3: When an operand's source matches only the memory/writeback producer (`mwb_rd` equal, `mwb_wen` 1, `mwb_rd` not 0), its select is 2'b10 and the operand equals the writeback value.
- R4: When both producers match the same source, the execute/memory producer wins: select 2'b01.
- R5: A producer whose write enable is 0 never causes forwarding, even if its destination index matches.
- R6: A producer whose destination index is 0 never causes forwarding, even with write enable 1.
- R7: With no live matching producer, the select is 2'b00 and the operand equals the register file read data for that source.
- R8: The writeback value is `mwb_load_data` when `mwb_is_load` is 1, and `mwb_alu_result` otherwise.
- R9: The A and B selections are independent. Both operands may take the same source, or different sources, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source register index of the instruction in execute |
| ex_rs2 | input | 5 | Second source register index of the instruction in execute |
| rf_rs1_data | input | 32 | Register file read data for the first source |
| rf_rs2_data | input | 32 | Register file read data for the second source |
| exm_rd | input | 5 | Destination index held in the execute/memory register |
| exm_wen | input | 1 | Register write enable held in the execute/memory register |
| exm_alu_result | input | 32 | ALU result held in the execute/memory register |
| mwb_rd | input | 5 | Destination index held in the memory/writeback register |
| mwb_wen | input | 1 | Register write enable held in the memory/writeback register |
| mwb_is_load | input | 1 | The memory/writeback instruction is a load |
| mwb_load_data | input | 32 | Load data held in the memory/writeback register |
| mwb_alu_result | input | 32 | ALU result held in the memory/writeback register |
| a_sel | output | 2 | A operand source: 00 register file, 01 execute/memory, 10 writeback |
| b_sel | output | 2 | B operand source, same encoding |
| alu_a | output | 32 | Selected A operand |
| alu_b | output | 32 | Selected B operand |

## Verification
The hardest case to reach is a double match. Both producers name the same register and both are enabled, and the pairing may also vary across the two operands. The test has to show that the newer producer wins and that the writeback value never leaks through. Uniform random 5-bit indices almost never line up like this. The stimulus therefore draws indices from a small set of four registers that includes register 0, and draws enables and the load flag at random. Double matches, matches on register 0, and disabled matches then occur often. Directed cases pin down each of these corners once.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    localparam int REG_AW = 5;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_EXM = 2'b01,
        SRC_MWB = 2'b10
    } op_src_e;

    typedef struct packed {
        logic [REG_AW-1:0] rd;
        logic              wen;
    } producer_t;

    function automatic logic producer_hits(input producer_t p, input logic [REG_AW-1:0] rs);
        return p.wen && (p.rd != '0) && (p.rd == rs);
    endfunction

endpackage

// File: rtl/opfwd_select.sv
module opfwd_select
    import opfwd_pkg::*;
(
    input  logic [REG_AW-1:0] rs,
    input  producer_t         exm,
    input  producer_t         mwb,
    output op_src_e           sel
);
    always_comb begin
        if (producer_hits(exm, rs))
            sel = SRC_EXM;
        else if (producer_hits(mwb, rs))
            sel = SRC_MWB;
        else
            sel = SRC_RF;
    end
endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux
    import opfwd_pkg::*;
#(
    parameter int W = 32
) (
    input  op_src_e      sel,
    input  logic [W-1:0] rf_val,
    input  logic [W-1:0] exm_val,
    input  logic [W-1:0] mwb_val,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            SRC_EXM: y = exm_val;
            SRC_MWB: y = mwb_val;
            default: y = rf_val;
        endcase
    end
endmodule

// File: rtl/opfwd_wbval.sv
module opfwd_wbval #(
    parameter int W = 32
) (
    input  logic         is_load,
    input  logic [W-1:0] load_data,
    input  logic [W-1:0] alu_result,
    output logic [W-1:0] wb_val
);
    assign wb_val = is_load ? load_data : alu_result;
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [XLEN-1:0]   rf_rs1_data,
    input  logic [XLEN-1:0]   rf_rs2_data,
    input  logic [REG_AW-1:0] exm_rd,
    input  logic              exm_wen,
    input  logic [XLEN-1:0]   exm_alu_result,
    input  logic [REG_AW-1:0] mwb_rd,
    input  logic              mwb_wen,
    input  logic              mwb_is_load,
    input  logic [XLEN-1:0]   mwb_load_data,
    input  logic [XLEN-1:0]   mwb_alu_result,
    output logic [1:0]        a_sel,
    output logic [1:0]        b_sel,
    output logic [XLEN-1:0]   alu_a,
    output logic [XLEN-1:0]   alu_b
);
    localparam int N_OPS = 2;

    producer_t         exm_p, mwb_p;
    logic [XLEN-1:0]   wb_val;
    logic [REG_AW-1:0] rs_v  [N_OPS];
    logic [XLEN-1:0]   rf_v  [N_OPS];
    logic [XLEN-1:0]   op_v  [N_OPS];
    op_src_e           sel_v [N_OPS];

    assign exm_p = '{rd: exm_rd, wen: exm_wen};
    assign mwb_p = '{rd: mwb_rd, wen: mwb_wen};
    assign rs_v[0] = ex_rs1;
    assign rs_v[1] = ex_rs2;
    assign rf_v[0] = rf_rs1_data;
    assign rf_v[1] = rf_rs2_data;

    opfwd_wbval #(.W(XLEN)) i_wbval (
        .is_load    (mwb_is_load),
        .load_data  (mwb_load_data),
        .alu_result (mwb_alu_result),
        .wb_val     (wb_val)
    );

    for (genvar k = 0; k < N_OPS; k++) begin : g_op
        opfwd_select i_sel (
            .rs  (rs_v[k]),
            .exm (exm_p),
            .mwb (mwb_p),
            .sel (sel_v[k])
        );
        opfwd_mux #(.W(XLEN)) i_mux (
            .sel     (sel_v[k]),
            .rf_val  (rf_v[k]),
            .exm_val (exm_alu_result),
            .mwb_val (wb_val),
            .y       (op_v[k])
        );
    end

    assign a_sel = sel_v[0];
    assign b_sel = sel_v[1];
    assign alu_a = op_v[0];
    assign alu_b = op_v[1];
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk
    import opfwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic [REG_AW-1:0] ex_rs1,
    input logic [REG_AW-1:0] ex_rs2,
    input logic [XLEN-1:0]   rf_rs1_data,
    input logic [XLEN-1:0]   rf_rs2_data,
    input logic [REG_AW-1:0] exm_rd,
    input logic              exm_wen,
    input logic [XLEN-1:0]   exm_alu_result,
    input logic [REG_AW-1:0] mwb_rd,
    input logic              mwb_wen,
    input logic              mwb_is_load,
    input logic [XLEN-1:0]   mwb_load_data,
    input logic [XLEN-1:0]   mwb_alu_result,
    input logic [1:0]        a_sel,
    input logic [1:0]        b_sel,
    input logic [XLEN-1:0]   alu_a,
    input logic [XLEN-1:0]   alu_b
);
    logic e_a, e_b, m_a, m_b;
    logic [XLEN-1:0] wbv;
    assign e_a = exm_wen && exm_rd != 0 && exm_rd == ex_rs1;
    assign e_b = exm_wen && exm_rd != 0 && exm_rd == ex_rs2;
    assign m_a = mwb_wen && mwb_rd != 0 && mwb_rd == ex_rs1;
    assign m_b = mwb_wen && mwb_rd != 0 && mwb_rd == ex_rs2;
    assign wbv = mwb_is_load ? mwb_load_data : mwb_alu_result;

    always_comb begin
        a_r1_exm_a: assert (!e_a || (a_sel == 2'b01 && alu_a == exm_alu_result));
        a_r2_exm_b: assert (!e_b || (b_sel == 2'b01 && alu_b == exm_alu_result));
        a_r3_mwb_a: assert (!(m_a && !e_a) || (a_sel == 2'b10 && alu_a == wbv));
        a_r3_mwb_b: assert (!(m_b && !e_b) || (b_sel == 2'b10 && alu_b == wbv));
        a_r7_rf_a:  assert (e_a || m_a || (a_sel == 2'b00 && alu_a == rf_rs1_data));
        a_r7_rf_b:  assert (e_b || m_b || (b_sel == 2'b00 && alu_b == rf_rs2_data));
        a_r6_x0_a:  assert (ex_rs1 != 0 || a_sel == 2'b00);
        a_r6_x0_b:  assert (ex_rs2 != 0 || b_sel == 2'b00);
        a_r5_sel_legal: assert (a_sel != 2'b11 && b_sel != 2'b11);
    end
endmodule

bind opfwd_unit opfwd_unit_chk #(.XLEN(XLEN)) i_opfwd_unit_chk (
    .ex_rs1         (ex_rs1),
    .ex_rs2         (ex_rs2),
    .rf_rs1_data    (rf_rs1_data),
    .rf_rs2_data    (rf_rs2_data),
    .exm_rd         (exm_rd),
    .exm_wen        (exm_wen),
    .exm_alu_result (exm_alu_result),
    .mwb_rd         (mwb_rd),
    .mwb_wen        (mwb_wen),
    .mwb_is_load    (mwb_is_load),
    .mwb_load_data  (mwb_load_data),
    .mwb_alu_result (mwb_alu_result),
    .a_sel          (a_sel),
    .b_sel          (b_sel),
    .alu_a          (alu_a),
    .alu_b          (alu_b)
);

// File: tb/test_opfwd_unit.sv
`timescale 1ns/1ps
module test_opfwd_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [4:0]  ex_rs1, ex_rs2, exm_rd, mwb_rd;
    logic [31:0] rf_rs1_data, rf_rs2_data, exm_alu_result, mwb_load_data, mwb_alu_result;
    logic        exm_wen, mwb_wen, mwb_is_load;
    logic [1:0]  a_sel, b_sel;
    logic [31:0] alu_a, alu_b;

    int n_run = 0;
    int n_fail = 0;

    opfwd_unit i_opfwd_unit (
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .rf_rs1_data(rf_rs1_data), .rf_rs2_data(rf_rs2_data),
        .exm_rd(exm_rd), .exm_wen(exm_wen), .exm_alu_result(exm_alu_result),
        .mwb_rd(mwb_rd), .mwb_wen(mwb_wen), .mwb_is_load(mwb_is_load),
        .mwb_load_data(mwb_load_data), .mwb_alu_result(mwb_alu_result),
        .a_sel(a_sel), .b_sel(b_sel), .alu_a(alu_a), .alu_b(alu_b)
    );

    function automatic logic [1:0] exp_sel(input logic [4:0] rs);
        if (exm_wen && exm_rd != 0 && exm_rd == rs) return 2'b01;
        if (mwb_wen && mwb_rd != 0 && mwb_rd == rs) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_op(input logic [1:0] s, input logic [31:0] rf);
        if (s == 2'b01) return exm_alu_result;
        if (s == 2'b10) return mwb_is_load ? mwb_load_data : mwb_alu_result;
        return rf;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] r1, input logic [4:0] r2,
                         input logic [4:0] erd, input logic ewe,
                         input logic [4:0] mrd, input logic mwe, input logic ld);
        @(posedge clk);
        ex_rs1 = r1; ex_rs2 = r2;
        exm_rd = erd; exm_wen = ewe;
        mwb_rd = mrd; mwb_wen = mwe; mwb_is_load = ld;
        rf_rs1_data = $urandom; rf_rs2_data = $urandom;
        exm_alu_result = $urandom; mwb_load_data = $urandom; mwb_alu_result = $urandom;
        @(negedge clk);
    endtask

    task automatic check_both(input string req);
        logic [1:0] ea, eb;
        ea = exp_sel(ex_rs1);
        eb = exp_sel(ex_rs2);
        chk({req, " a_sel"}, {30'd0, a_sel}, {30'd0, ea});
        chk({req, " alu_a"}, alu_a, exp_op(ea, rf_rs1_data));
        chk({req, " b_sel"}, {30'd0, b_sel}, {30'd0, eb});
        chk({req, " alu_b"}, alu_b, exp_op(eb, rf_rs2_data));
    endtask

    initial begin
        #50000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
        @(posedge clk); rst = 1'b0; @(negedge clk);
        // R7 idle state: nothing live, register file passes through
        chk("R7 idle a_sel", {30'd0, a_sel}, 32'd0);
        chk("R7 idle alu_a", alu_a, rf_rs1_data);
        drive(5'd3, 5'd4, 5'd3, 1'b1, 5'd9, 1'b1, 1'b0);
        chk("R1 exm to A", {30'd0, a_sel}, 32'd1);
        chk("R1 exm data", alu_a, exm_alu_result);
        drive(5'd8, 5'd6, 5'd6, 1'b1, 5'd9, 1'b0, 1'b0);
        chk("R2 exm to B", alu_b, exm_alu_result);
        drive(5'd7, 5'd2, 5'd1, 1'b1, 5'd7, 1'b1, 1'b1);
        chk("R3 R8 mwb load to A", alu_a, mwb_load_data);
        chk("R3 mwb sel", {30'd0, a_sel}, 32'd2);
        drive(5'd7, 5'd7, 5'd1, 1'b1, 5'd7, 1'b1, 1'b0);
        chk("R8 mwb alu to B", alu_b, mwb_alu_result);
        drive(5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1, 1'b1);
        chk("R4 newer wins A", {30'd0, a_sel}, 32'd1);
        chk("R4 newer wins B", alu_b, exm_alu_result);
        drive(5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b0, 1'b0);
        chk("R5 disabled A", alu_a, rf_rs1_data);
        chk("R5 disabled B", {30'd0, b_sel}, 32'd0);
        drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1);
        chk("R6 x0 A", alu_a, rf_rs1_data);
        chk("R6 x0 B", alu_b, rf_rs2_data);
        drive(5'd3, 5'd9, 5'd3, 1'b1, 5'd9, 1'b1, 1'b0);
        chk("R9 A exm", {30'd0, a_sel}, 32'd1);
        chk("R9 B mwb", {30'd0, b_sel}, 32'd2);
        for (int i = 0; i < 2000; i++) begin
            drive(5'($urandom_range(3)), 5'($urandom_range(3)),
                  5'($urandom_range(3)), 1'($urandom), 5'($urandom_range(3)),
                  1'($urandom), 1'($urandom));
            check_both("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule